// File: doc/BRIEF.md
# Guarded single-precision less-than comparator

This unit compares two IEEE-754 single-precision operands and produces an integer result. The result is 1 when the first operand is strictly smaller than the second and 0 in every other case. An operation is issued with a valid strobe, a guard bit and two operand words. When the guard bit is set, the registered result reaches the destination write port one clock later. When the guard bit is clear, the operation is dropped completely.

Before the comparison, subnormal operands are treated as zero. A NaN operand forces the result to 0. Both conditions are recorded in a small sticky exception status register. That register also merges flag reports from neighbouring floating-point units arriving in the same cycle. Software can read it through the status port, and an explicit status write replaces its contents.

Top module: `fcmp_lt_unit`

## Requirements
- R1: A guarded operation accepted at a clock edge raises `dst_we` for exactly the following cycle. `dst_data` then holds 32'd1 if A < B numerically and 32'd0 otherwise, so bits 31..1 are always zero.
- R2: An operand with exponent field 0 and a nonzero fraction compares as zero. A committed operation with such an operand sets status bit 1 (flush flag).
- R3: An operand with exponent field 255 and a nonzero fraction is a NaN. It forces a result of 0, and a committed operation sets status bit 0 (invalid flag).
- R4: Equal operands give 0. +0 and -0 are equal in either order.
- R5: Ordering follows the sign first and then the magnitude, with the magnitude sense reversed when both operands are negative. Infinities are ordered like other values, so +INF < -INF gives 0 and -INF < 1.0 gives 1.
- R6: When `op_guard` is 0 the destination is not written, `dst_data` keeps its value, and the operation changes no status bit.
- R7: Status bits are sticky. Without a status write, a bit that is set stays set whatever operations follow.
- R8: Each bit of `ext_flags` is ORed into the status register at the same edge, whether or not an operation is issued.
- R9: A status write loads `stat_wdata` into the status register. It overrides any set from an operation or from `ext_flags` in the same cycle.
- R10: During and after reset, `dst_we`, `dst_data` and `stat_flags` are 0.
- R11: The flag update of a committed operation becomes visible in the same cycle as its destination write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Operation issued this cycle |
| op_guard | input | 1 | Least significant bit of the guard register; 1 commits the operation |
| op_a | input | 32 | First operand (single precision) |
| op_b | input | 32 | Second operand (single precision) |
| ext_flags | input | 2 | Flag sets reported by other units this cycle (bit 0 invalid, bit 1 flush) |
| stat_wr | input | 1 | Explicit status write |
| stat_wdata | input | 2 | Value loaded by a status write |
| dst_we | output | 1 | Destination register write enable |
| dst_data | output | 32 | Integer comparison result |
| stat_flags | output | 2 | Sticky status: bit 0 invalid, bit 1 flush |

## Verification
The hardest case to reach is one edge at which three things coincide: a committed NaN or subnormal comparison, a flag set from `ext_flags`, and a status write. Only the write value may survive that edge, while the destination write must still happen. The stimulus drives all three in a single cycle, both with the written value clearing bits and with it setting a bit nobody else raised. It then follows up with clean comparisons to show that the restored state persists. False-guard operations carrying NaN and subnormal operands are placed straight after known results, so that any leak into either the destination or the status register shows at the ports.

// File: rtl/fcmp_pkg.sv
// Shared definitions for the guarded less-than comparator.
// Assumes a two-bit exception status: invalid and flush-to-zero.
package fcmp_pkg;
    localparam int FLAG_W   = 2;
    localparam int FLAG_INV = 0;
    localparam int FLAG_IFZ = 1;

    // Classification of one operand after decoding its fields
    typedef struct packed {
        logic is_nan;
        logic is_den;
        logic is_zero;
    } opnd_cls_t;
endpackage

// File: rtl/fcmp_classify.sv
// Decodes one floating-point operand: flags NaN and subnormal values and
// returns a sign/magnitude pair with subnormals and zeros flushed to +0.
// Assumes an IEEE-style layout {sign, exponent, fraction}.
module fcmp_classify
    import fcmp_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic [EXP_W+MAN_W:0]   raw,
    output opnd_cls_t              cls,
    output logic                   sgn,
    output logic [EXP_W+MAN_W-1:0] mag
);
    localparam int DW = 1 + EXP_W + MAN_W;

    logic [EXP_W-1:0] exp_f;
    logic [MAN_W-1:0] man_f;
    logic             exp_ones;
    logic             exp_none;
    logic             man_any;

    assign exp_f = raw[DW-2 -: EXP_W];
    assign man_f = raw[MAN_W-1:0];

    // Field decode and flush of subnormals to an unsigned zero
    always_comb begin
        exp_ones    = &exp_f;
        exp_none    = ~|exp_f;
        man_any     = |man_f;
        cls.is_nan  = exp_ones & man_any;
        cls.is_den  = exp_none & man_any;
        cls.is_zero = exp_none;
        sgn         = exp_none ? 1'b0 : raw[DW-1];
        mag         = exp_none ? '0 : raw[DW-2:0];
    end
endmodule

// File: rtl/fcmp_order.sv
// Strict less-than over two flushed sign/magnitude operands.
// Assumes zeros arrive with sign 0 and magnitude 0; any NaN yields 0.
module fcmp_order #(
    parameter int MAG_W = 31
) (
    input  logic             sgn_a,
    input  logic [MAG_W-1:0] mag_a,
    input  logic             nan_a,
    input  logic             sgn_b,
    input  logic [MAG_W-1:0] mag_b,
    input  logic             nan_b,
    output logic             less
);
    // Sign-first ordering, magnitude sense flipped for two negatives
    always_comb begin
        if (nan_a || nan_b) begin
            less = 1'b0;
        end else begin
            unique case ({sgn_a, sgn_b})
                2'b10:   less = 1'b1;
                2'b01:   less = 1'b0;
                2'b11:   less = (mag_a > mag_b);
                default: less = (mag_a < mag_b);
            endcase
        end
    end
endmodule

// File: rtl/fcmp_sticky.sv
// Sticky exception status register. Sets from this unit and from other
// units are ORed in; an explicit write replaces the contents and wins.
module fcmp_sticky #(
    parameter int FLAG_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FLAG_W-1:0] set_own,
    input  logic [FLAG_W-1:0] set_ext,
    input  logic              wr_en,
    input  logic [FLAG_W-1:0] wr_data,
    output logic [FLAG_W-1:0] flags
);
    // Status update: write has priority over accumulated sets
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '0;
        end else if (wr_en) begin
            flags <= wr_data;
        end else begin
            flags <= flags | set_own | set_ext;
        end
    end
endmodule

// File: rtl/fcmp_lt_unit.sv
// Guarded single-precision less-than unit. Classifies both operands,
// orders them and registers the 0/1 result together with the sticky
// exception status, so both become visible in the same cycle.
// Assumes op_guard carries only the guard register's least significant bit.
module fcmp_lt_unit
    import fcmp_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   op_valid,
    input  logic                   op_guard,
    input  logic [EXP_W+MAN_W:0]   op_a,
    input  logic [EXP_W+MAN_W:0]   op_b,
    input  logic [FLAG_W-1:0]      ext_flags,
    input  logic                   stat_wr,
    input  logic [FLAG_W-1:0]      stat_wdata,
    output logic                   dst_we,
    output logic [EXP_W+MAN_W:0]   dst_data,
    output logic [FLAG_W-1:0]      stat_flags
);
    localparam int DW    = 1 + EXP_W + MAN_W;
    localparam int MAG_W = DW - 1;
    localparam int N_OP  = 2;

    logic [DW-1:0]    opnd [N_OP];
    opnd_cls_t        cls  [N_OP];
    logic             sgn  [N_OP];
    logic [MAG_W-1:0] mag  [N_OP];
    logic             less;
    logic             commit;
    logic [FLAG_W-1:0] own_set;

    assign opnd[0] = op_a;
    assign opnd[1] = op_b;

    for (genvar gi = 0; gi < N_OP; gi++) begin : g_cls
        fcmp_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
            .raw (opnd[gi]),
            .cls (cls[gi]),
            .sgn (sgn[gi]),
            .mag (mag[gi])
        );
    end

    fcmp_order #(.MAG_W(MAG_W)) u_order (
        .sgn_a (sgn[0]),
        .mag_a (mag[0]),
        .nan_a (cls[0].is_nan),
        .sgn_b (sgn[1]),
        .mag_b (mag[1]),
        .nan_b (cls[1].is_nan),
        .less  (less)
    );

    // Commit decision and the flag sets it produces
    always_comb begin
        commit            = op_valid & op_guard;
        own_set           = '0;
        own_set[FLAG_INV] = commit & (cls[0].is_nan | cls[1].is_nan);
        own_set[FLAG_IFZ] = commit & (cls[0].is_den | cls[1].is_den);
    end

    fcmp_sticky #(.FLAG_W(FLAG_W)) u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_own (own_set),
        .set_ext (ext_flags),
        .wr_en   (stat_wr),
        .wr_data (stat_wdata),
        .flags   (stat_flags)
    );

    // Destination write path, held when no operation commits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dst_we   <= 1'b0;
            dst_data <= '0;
        end else begin
            dst_we <= commit;
            if (commit) begin
                dst_data <= {{(DW-1){1'b0}}, less};
            end
        end
    end
endmodule

// File: rtl/fcmp_lt_checker.sv
// Temporal checks for fcmp_lt_unit, attached through bind.
module fcmp_lt_checker
    import fcmp_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 op_valid,
    input logic                 op_guard,
    input logic [EXP_W+MAN_W:0] op_a,
    input logic [EXP_W+MAN_W:0] op_b,
    input logic [FLAG_W-1:0]    ext_flags,
    input logic                 stat_wr,
    input logic [FLAG_W-1:0]    stat_wdata,
    input logic                 dst_we,
    input logic [EXP_W+MAN_W:0] dst_data,
    input logic [FLAG_W-1:0]    stat_flags
);
    localparam int DW = 1 + EXP_W + MAN_W;

    logic a_nan;
    logic b_nan;
    assign a_nan = (&op_a[DW-2 -: EXP_W]) & (|op_a[MAN_W-1:0]);
    assign b_nan = (&op_b[DW-2 -: EXP_W]) & (|op_b[MAN_W-1:0]);

    p_result_bool_r1: assert property (@(posedge clk) disable iff (!rst_n)
        dst_we |-> (dst_data[DW-1:1] == '0));

    p_write_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_guard) |=> dst_we);

    p_nan_result_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_guard && (a_nan || b_nan) && !stat_wr)
        |=> (dst_data == '0) && stat_flags[FLAG_INV]);

    p_no_commit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!(op_valid && op_guard)) |=> !dst_we && $stable(dst_data));

    p_guard_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!(op_valid && op_guard) && !stat_wr && (ext_flags == '0))
        |=> $stable(stat_flags));

    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_wr |=> ((stat_flags & $past(stat_flags)) == $past(stat_flags)));

    p_ext_merge_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_wr |=> ((stat_flags & $past(ext_flags)) == $past(ext_flags)));

    p_write_prio_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stat_wr |=> (stat_flags == $past(stat_wdata)));
endmodule

bind fcmp_lt_unit fcmp_lt_checker #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_valid   (op_valid),
    .op_guard   (op_guard),
    .op_a       (op_a),
    .op_b       (op_b),
    .ext_flags  (ext_flags),
    .stat_wr    (stat_wr),
    .stat_wdata (stat_wdata),
    .dst_we     (dst_we),
    .dst_data   (dst_data),
    .stat_flags (stat_flags)
);

// File: tb/fcmp_lt_unit_bench.sv
// Scoreboard bench: the driver predicts every cycle's outputs from a
// real-number model and queues them; the monitor compares after each edge.
module fcmp_lt_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic        op_guard = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic [1:0]  ext_flags = '0;
    logic        stat_wr = 1'b0;
    logic [1:0]  stat_wdata = '0;
    logic        dst_we;
    logic [31:0] dst_data;
    logic [1:0]  stat_flags;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    typedef struct {
        logic        we;
        logic [31:0] data;
        logic [1:0]  stat;
        string       req;
    } exp_t;
    exp_t sb_q[$];

    logic [31:0] m_data = '0;
    logic [1:0]  m_stat = '0;

    always #2 clk = ~clk;

    fcmp_lt_unit u_fcmp_lt_unit (
        .clk (clk), .rst_n (rst_n), .op_valid (op_valid), .op_guard (op_guard),
        .op_a (op_a), .op_b (op_b), .ext_flags (ext_flags), .stat_wr (stat_wr),
        .stat_wdata (stat_wdata), .dst_we (dst_we), .dst_data (dst_data),
        .stat_flags (stat_flags)
    );

    function automatic void chk(bit ok, string req, string what,
                                logic [31:0] act, logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
        end
    endfunction

    function automatic bit is_nan(logic [31:0] x);
        return (x[30:23] == 8'hff) && (x[22:0] != 0);
    endfunction

    function automatic bit is_den(logic [31:0] x);
        return (x[30:23] == 8'h00) && (x[22:0] != 0);
    endfunction

    // Real value of an operand, subnormals flushed, infinities as huge
    function automatic real to_real(logic [31:0] x);
        int  e;
        real m;
        e = int'(x[30:23]);
        if (e == 0) return 0.0;
        if (e == 255) return x[31] ? -1.0e300 : 1.0e300;
        m = (1.0 + real'(x[22:0]) / 8388608.0) * (2.0 ** real'(e - 127));
        return x[31] ? -m : m;
    endfunction

    // Drive one cycle and queue the outputs expected after its edge
    task automatic drive(input logic v, input logic g, input logic [31:0] a,
                         input logic [31:0] b, input logic [1:0] ext,
                         input logic wr, input logic [1:0] wd, input string req);
        exp_t       it;
        logic       com;
        logic [1:0] fl;
        @(negedge clk);
        op_valid = v; op_guard = g; op_a = a; op_b = b;
        ext_flags = ext; stat_wr = wr; stat_wdata = wd;
        com = v & g;
        fl  = {is_den(a) | is_den(b), is_nan(a) | is_nan(b)};
        if (com) begin
            m_data = (!is_nan(a) && !is_nan(b) && (to_real(a) < to_real(b))) ? 32'd1 : 32'd0;
        end
        m_stat  = wr ? wd : (m_stat | (com ? fl : 2'b00) | ext);
        it.we   = com;
        it.data = m_data;
        it.stat = m_stat;
        it.req  = req;
        sb_q.push_back(it);
    endtask

    task automatic cmp(input logic [31:0] a, input logic [31:0] b, input string req);
        drive(1'b1, 1'b1, a, b, 2'b00, 1'b0, 2'b00, req);
    endtask

    task automatic idle(input string req);
        drive(1'b0, 1'b0, '0, '0, 2'b00, 1'b0, 2'b00, req);
    endtask

    // Monitor: compare after each edge, one queued item per cycle
    always @(posedge clk) begin
        exp_t it;
        #1;
        if (rst_n && sb_q.size() > 0) begin
            it = sb_q.pop_front();
            chk(dst_we == it.we, it.req, "dst_we", {31'b0, dst_we}, {31'b0, it.we});
            chk(dst_data == it.data, it.req, "dst_data", dst_data, it.data);
            chk(stat_flags == it.stat, it.req, "stat_flags (R11 same cycle)",
                {30'b0, stat_flags}, {30'b0, it.stat});
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] ra;
        logic [31:0] rb;
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(dst_we == 1'b0, "R10", "dst_we in reset", {31'b0, dst_we}, 32'd0);
        chk(dst_data == 32'd0, "R10", "dst_data in reset", dst_data, 32'd0);
        chk(stat_flags == 2'b00, "R10", "stat in reset", {30'b0, stat_flags}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(dst_we == 1'b0 && stat_flags == 2'b00, "R10", "after reset",
            {29'b0, dst_we, stat_flags}, 32'd0);

        // R1 basic ordering
        cmp(32'h3f800000, 32'h40400000, "R1");   // 1.0 < 3.0
        cmp(32'h40400000, 32'h00000000, "R1");   // 3.0 < 0.0
        // R4 equality and signed zeros
        cmp(32'h40400000, 32'h40400000, "R4");
        cmp(32'h00000000, 32'h80000000, "R4");
        cmp(32'h80000000, 32'h00000000, "R4");
        // R5 negatives and infinities
        cmp(32'hc0000000, 32'hbf800000, "R5");   // -2 < -1
        cmp(32'hbf800000, 32'hc0000000, "R5");   // -1 < -2
        cmp(32'h7f800000, 32'hff800000, "R5");   // +INF < -INF
        cmp(32'hff800000, 32'h3f800000, "R5");   // -INF < 1
        cmp(32'h7f800000, 32'h7f800000, "R5");
        // R6 false guard, with a would-be flag source
        drive(1'b1, 1'b0, 32'hffffffff, 32'h00400000, 2'b00, 1'b0, 2'b00, "R6");
        idle("R6");
        // R2 subnormal flush
        cmp(32'h3f800000, 32'h00400000, "R2");   // 1.0 < den -> 0
        cmp(32'h00400000, 32'h3f800000, "R2");   // den < 1.0 -> 1
        cmp(32'h80400000, 32'h00000000, "R2");   // -den < 0 -> 0
        // R3 NaN
        cmp(32'h40400000, 32'hffffffff, "R3");
        cmp(32'h7fc00000, 32'h3f800000, "R3");
        // R7 sticky through clean ops
        cmp(32'h3f800000, 32'h40400000, "R7");
        idle("R7");
        // R9 clear, then write wins over simultaneous NaN and ext sets
        drive(1'b0, 1'b0, '0, '0, 2'b00, 1'b1, 2'b00, "R9");
        drive(1'b1, 1'b1, 32'h7fc00000, 32'h00400000, 2'b11, 1'b1, 2'b00, "R9");
        drive(1'b1, 1'b1, 32'h7fc00000, 32'h3f800000, 2'b01, 1'b1, 2'b10, "R9");
        cmp(32'h3f800000, 32'h40400000, "R9");
        drive(1'b0, 1'b0, '0, '0, 2'b00, 1'b1, 2'b00, "R9");
        // R8 external sets alone and with an operation
        drive(1'b0, 1'b0, '0, '0, 2'b10, 1'b0, 2'b00, "R8");
        drive(1'b1, 1'b1, 32'hc0400000, 32'h3f800000, 2'b01, 1'b0, 2'b00, "R8");
        drive(1'b0, 1'b0, '0, '0, 2'b00, 1'b1, 2'b00, "R8");
        // R6 false guard while flags clear
        drive(1'b1, 1'b0, 32'h7fc00000, 32'h00000001, 2'b00, 1'b0, 2'b00, "R6");
        // R1 mixed normal operands
        for (int i = 0; i < 60; i++) begin
            ra = {$urandom_range(1, 0) == 1, 8'($urandom_range(254, 1)), 23'($urandom)};
            rb = (i % 5 == 0) ? ra : {$urandom_range(1, 0) == 1,
                                      8'($urandom_range(254, 1)), 23'($urandom)};
            if (i % 7 == 0) rb[30:23] = ra[30:23];
            cmp(ra, rb, "R1");
        end
        repeat (3) idle("R1");
        @(negedge clk);
        chk(sb_q.size() == 0, "R1", "queue drained", sb_q.size(), 32'd0);
        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule